// File: doc/BRIEF.md
# Time-of-Day Clock with Periodic Tick Interrupt

This block keeps wall-clock time as a pair of counters, whole seconds and microseconds within the current second. The microsecond counter advances from a prescaler derived from the known core clock frequency. Software never reads the running counters directly. An access to the trigger offset copies both counters into snapshot registers in a single cycle. Two later reads then return a seconds/microseconds pair that belongs to one instant. The seconds counter can be written, so boot code can load the epoch time.

A second function raises a periodic interrupt. Software writes a rate in ticks per second. A phase accumulator, stepped once per microsecond, produces ticks at that average rate. Each tick adds one to a saturating pending counter, and the interrupt line is high while that counter is non-zero. Every access to the acknowledge offset retires exactly one pending tick, so bursts of ticks are not lost when service is late. A rate of zero stops tick generation.

Top module: `rtc_tick_timer`

## Requirements
- R1: An access (read or write) at offset 0x000 copies the live seconds and microseconds into snapshot registers at that clock edge; the snapshots keep their value in every other cycle, and a read at 0x000 returns 0.
- R2: The microsecond counter advances by one every CLK_HZ/1000000 clocks and wraps from US_PER_S-1 to 0, adding one to the seconds counter at the wrap, so seconds*US_PER_S+microseconds grows by exactly one per microsecond.
- R3: A read at 0x010 returns the snapshot seconds and a read at 0x020 the snapshot microseconds; a write at 0x010 loads the live seconds counter and takes priority over a carry in the same cycle.
- R4: A write at 0x100 sets the tick rate and a read returns it; a value above US_PER_S is stored as US_PER_S; every rate write restarts the tick phase from zero, so a tick falls no earlier than US_PER_S/rate whole microseconds after the write.
- R5: With a rate of 0 no tick is produced and the pending count does not grow.
- R6: With rate f, ticks are generated at an average of f per US_PER_S microseconds (one every US_PER_S/f microseconds when f divides US_PER_S), each adding one to the pending count.
- R7: Any access at 0x110 retires one pending tick when the count is non-zero and leaves 0 at 0; a read there returns the count before the retirement; a tick and an acknowledge in the same cycle leave the count unchanged.
- R8: The pending count saturates at 2^PEND_W-1, and irq_o is 1 exactly when the pending count is non-zero.
- R9: After reset the counters, snapshots, rate and pending count are 0 and irq_o is 0; a read at any offset other than 0x010, 0x020, 0x100 and 0x110 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock of frequency CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the offset on addr_i, valid in the access cycle |
| irq_o | output | 1 | Periodic interrupt, high while ticks are pending |

## Verification
The tick generator and the acknowledge decoder can both act on the pending counter at one edge. The bench runs the rate at one tick per microsecond until the counter saturates. It then issues four acknowledges on four consecutive edges, so that exactly one of them meets a tick, whatever the prescaler phase. The count read afterwards must be the saturated value minus four plus one. The checker also tests every edge where tick and acknowledge coincide and requires the count to hold.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned OFF_TRIG = 'h000;
  localparam int unsigned OFF_SEC  = 'h010;
  localparam int unsigned OFF_USEC = 'h020;
  localparam int unsigned OFF_RATE = 'h100;
  localparam int unsigned OFF_ACK  = 'h110;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_TRIG,
    ACC_SEC,
    ACC_USEC,
    ACC_RATE,
    ACC_ACK
  } acc_e;

endpackage

// File: rtl/rtc_us_base.sv
module rtc_us_base #(
  parameter int unsigned CLKS_PER_US = 100,
  parameter int unsigned US_PER_S    = 1000000,
  parameter int unsigned SEC_W       = 32,
  localparam int unsigned PS_W       = $clog2(CLKS_PER_US + 1),
  localparam int unsigned US_W       = $clog2(US_PER_S)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_load_i,
  input  logic [SEC_W-1:0] sec_wdata_i,
  output logic             us_stb_o,
  output logic [US_W-1:0]  us_o,
  output logic [SEC_W-1:0] sec_o
);

  logic [PS_W-1:0]  ps_q, ps_d;
  logic [US_W-1:0]  us_q, us_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             wrap;

  always_comb begin
    us_stb_o = (ps_q == PS_W'(CLKS_PER_US - 1));
    wrap     = us_stb_o && (us_q == US_W'(US_PER_S - 1));
    ps_d     = us_stb_o ? '0 : ps_q + PS_W'(1);
    us_d     = us_q;
    sec_d    = sec_q;
    if (us_stb_o) begin
      us_d = wrap ? '0 : us_q + US_W'(1);
    end
    if (sec_load_i) begin
      sec_d = sec_wdata_i;
    end else if (wrap) begin
      sec_d = sec_q + SEC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= '0;
      us_q  <= '0;
      sec_q <= '0;
    end else begin
      ps_q  <= ps_d;
      us_q  <= us_d;
      sec_q <= sec_d;
    end
  end

  assign us_o  = us_q;
  assign sec_o = sec_q;

endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen #(
  parameter int unsigned US_PER_S = 1000000,
  localparam int unsigned FRQ_W   = $clog2(US_PER_S + 1),
  localparam int unsigned ACC_W   = FRQ_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             us_stb_i,
  input  logic             restart_i,
  input  logic [FRQ_W-1:0] rate_i,
  output logic             tick_o
);

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             acc_en, over;

  always_comb begin
    sum    = acc_q + ACC_W'(rate_i);
    over   = (sum >= ACC_W'(US_PER_S));
    acc_en = restart_i || (us_stb_i && (rate_i != '0));
    acc_d  = acc_q;
    if (restart_i) begin
      acc_d = '0;
    end else if (over) begin
      acc_d = sum - ACC_W'(US_PER_S);
    end else begin
      acc_d = sum;
    end
    tick_o = us_stb_i && (rate_i != '0) && over && !restart_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/rtc_pend_ctr.sv
module rtc_pend_ctr #(
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              ack_i,
  output logic [PEND_W-1:0] pend_o
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              dec;

  always_comb begin
    dec    = ack_i && (pend_q != '0);
    pend_d = pend_q;
    unique case ({inc_i, dec})
      2'b10:   pend_d = (pend_q == PEND_MAX) ? pend_q : pend_q + PEND_W'(1);
      2'b01:   pend_d = pend_q - PEND_W'(1);
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100000000,
  parameter int unsigned US_PER_S = 1000000,
  parameter int unsigned PEND_W   = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int unsigned CLKS_PER_US = CLK_HZ / 1000000;
  localparam int unsigned US_W        = $clog2(US_PER_S);
  localparam int unsigned FRQ_W       = $clog2(US_PER_S + 1);
  localparam int unsigned SEC_W       = DATA_W;

  // reset: asynchronous assertion, two-flop synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n = rst_pipe[1];

  // access decode
  acc_e acc;
  logic trig, sec_load, rate_we, ack;

  always_comb begin
    acc = ACC_NONE;
    if (req_i) begin
      if (addr_i == ADDR_W'(OFF_TRIG))      acc = ACC_TRIG;
      else if (addr_i == ADDR_W'(OFF_SEC))  acc = ACC_SEC;
      else if (addr_i == ADDR_W'(OFF_USEC)) acc = ACC_USEC;
      else if (addr_i == ADDR_W'(OFF_RATE)) acc = ACC_RATE;
      else if (addr_i == ADDR_W'(OFF_ACK))  acc = ACC_ACK;
      else                                  acc = ACC_NONE;
    end
    trig     = (acc == ACC_TRIG);
    sec_load = (acc == ACC_SEC) && we_i;
    rate_we  = (acc == ACC_RATE) && we_i;
    ack      = (acc == ACC_ACK);
  end

  // time base
  logic             us_stb;
  logic [US_W-1:0]  us_live;
  logic [SEC_W-1:0] sec_live;

  rtc_us_base #(
    .CLKS_PER_US(CLKS_PER_US),
    .US_PER_S   (US_PER_S),
    .SEC_W      (SEC_W)
  ) i_base (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sec_load_i (sec_load),
    .sec_wdata_i(wdata_i[SEC_W-1:0]),
    .us_stb_o   (us_stb),
    .us_o       (us_live),
    .sec_o      (sec_live)
  );

  // snapshot registers
  logic [US_W-1:0]  snap_us_q, snap_us_d;
  logic [SEC_W-1:0] snap_sec_q, snap_sec_d;

  always_comb begin
    snap_us_d  = trig ? us_live  : snap_us_q;
    snap_sec_d = trig ? sec_live : snap_sec_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      snap_us_q  <= '0;
      snap_sec_q <= '0;
    end else if (trig) begin
      snap_us_q  <= snap_us_d;
      snap_sec_q <= snap_sec_d;
    end
  end

  // rate register with clamp
  logic [FRQ_W-1:0] rate_q, rate_d;

  always_comb begin
    if (wdata_i > DATA_W'(US_PER_S)) begin
      rate_d = FRQ_W'(US_PER_S);
    end else begin
      rate_d = wdata_i[FRQ_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
    end else if (rate_we) begin
      rate_q <= rate_d;
    end
  end

  // tick generation and pending count
  logic              tick;
  logic [PEND_W-1:0] pend;

  rtc_rate_gen #(
    .US_PER_S(US_PER_S)
  ) i_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .us_stb_i (us_stb),
    .restart_i(rate_we),
    .rate_i   (rate_q),
    .tick_o   (tick)
  );

  rtc_pend_ctr #(
    .PEND_W(PEND_W)
  ) i_pend (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .inc_i (tick),
    .ack_i (ack),
    .pend_o(pend)
  );

  assign irq_o = (pend != '0);

  // read data
  always_comb begin
    unique case (acc)
      ACC_SEC:  rdata_o = DATA_W'(snap_sec_q);
      ACC_USEC: rdata_o = DATA_W'(snap_us_q);
      ACC_RATE: rdata_o = DATA_W'(rate_q);
      ACC_ACK:  rdata_o = DATA_W'(pend);
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/rtc_tick_chk.sv
module rtc_tick_chk #(
  parameter int unsigned US_PER_S = 1000000,
  parameter int unsigned PEND_W   = 4,
  parameter int unsigned SEC_W    = 32,
  localparam int unsigned US_W    = $clog2(US_PER_S)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              us_stb_i,
  input logic [US_W-1:0]   us_i,
  input logic [SEC_W-1:0]  sec_i,
  input logic              sec_load_i,
  input logic [SEC_W-1:0]  sec_wdata_i,
  input logic              trig_i,
  input logic [US_W-1:0]   snap_us_i,
  input logic [SEC_W-1:0]  snap_sec_i,
  input logic              rate_zero_i,
  input logic              tick_i,
  input logic              ack_i,
  input logic [PEND_W-1:0] pend_i,
  input logic              irq_i
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  p_snap_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> ($stable(snap_us_i) && $stable(snap_sec_i)));

  p_snap_take_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (snap_sec_i == $past(sec_i)));

  p_us_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    us_i < US_W'(US_PER_S));

  p_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (us_stb_i && us_i == US_W'(US_PER_S - 1) && !sec_load_i)
      |=> (us_i == '0 && sec_i == $past(sec_i) + SEC_W'(1)));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_load_i |=> (sec_i == $past(sec_wdata_i)));

  p_off_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_zero_i |-> !tick_i);

  p_one_retire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick_i && pend_i != '0) |=> (pend_i == $past(pend_i) - PEND_W'(1)));

  p_tick_ack_same_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && tick_i && pend_i != '0) |=> $stable(pend_i));

  p_saturate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == PEND_MAX && !ack_i) |=> (pend_i == PEND_MAX));

  p_irq_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == PEND_W'(1) && ack_i && !tick_i) |=> !irq_i);

endmodule

bind rtc_tick_timer rtc_tick_chk #(
  .US_PER_S(US_PER_S),
  .PEND_W  (PEND_W),
  .SEC_W   (SEC_W)
) i_rtc_tick_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n),
  .us_stb_i   (us_stb),
  .us_i       (us_live),
  .sec_i      (sec_live),
  .sec_load_i (sec_load),
  .sec_wdata_i(wdata_i[SEC_W-1:0]),
  .trig_i     (trig),
  .snap_us_i  (snap_us_q),
  .snap_sec_i (snap_sec_q),
  .rate_zero_i(rate_q == '0),
  .tick_i     (tick),
  .ack_i      (ack),
  .pend_i     (pend),
  .irq_i      (irq_o)
);

// File: tb/test_rtc_tick_timer.sv
module test_rtc_tick_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4000000;   // 4 clocks per microsecond
  localparam int US_PER_S   = 50;
  localparam int PEND_W     = 4;
  localparam int PEND_MAX   = 15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  rtc_tick_timer #(
    .CLK_HZ  (CLK_HZ),
    .US_PER_S(US_PER_S),
    .PEND_W  (PEND_W)
  ) i_rtc_tick_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  // vector: we, offset, write data, expected read data
  localparam int NV = 7;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h100, 32'd10, 32'd0},
    {1'b0, 12'h100, 32'd0,  32'd10},
    {1'b1, 12'h100, 32'd0,  32'd0},
    {1'b0, 12'h100, 32'd0,  32'd0},
    {1'b0, 12'h030, 32'd0,  32'd0},
    {1'b0, 12'h000, 32'd0,  32'd0},
    {1'b0, 12'h200, 32'd0,  32'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; one rising edge passes; returns at the next negedge
  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    #1 rd = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    idle(4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, u1, s1, u2, s2, u3;
    @(negedge clk_i);
    do_reset();

    // R9 reset state
    check("R9 irq after reset", {31'd0, irq_o}, 32'd0);
    access(1'b0, 12'h100, 0, rd); check("R9 rate after reset", rd, 0);
    access(1'b0, 12'h010, 0, rd); check("R9 snap sec after reset", rd, 0);
    access(1'b0, 12'h020, 0, rd); check("R9 snap us after reset", rd, 0);
    access(1'b0, 12'h110, 0, rd); check("R9 pending after reset", rd, 0);

    // R4 / R9 table of register accesses
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][76], VEC[i][75:64], VEC[i][63:32], rd);
      if (!VEC[i][76]) check("R4/R9 table read", rd, VEC[i][31:0]);
    end

    // R5 rate 0 gives no ticks
    idle(200);
    access(1'b0, 12'h110, 0, rd); check("R5 no pending with rate 0", rd, 0);
    check("R5 irq low with rate 0", {31'd0, irq_o}, 32'd0);

    // R1 R2 R3 snapshot, hold, exact advance of 100 us over 400 edges
    access(1'b0, 12'h000, 0, rd);          // edge T
    access(1'b0, 12'h020, 0, u1);          // T+1
    access(1'b0, 12'h010, 0, s1);          // T+2
    check("R2 us below wrap", {31'd0, u1 < US_PER_S}, 32'd1);
    idle(396);                             // T+3..T+398
    access(1'b0, 12'h020, 0, u3);          // T+399
    check("R1 snapshot holds without trigger", u3, u1);
    access(1'b0, 12'h000, 0, rd);          // T+400
    access(1'b0, 12'h020, 0, u2);
    access(1'b0, 12'h010, 0, s2);
    check("R2 time advance across wraps", (s2 * US_PER_S + u2) - (s1 * US_PER_S + u1), 100);

    // R3 seconds load
    access(1'b1, 12'h010, 32'd1000, rd);
    access(1'b1, 12'h000, 0, rd);
    access(1'b0, 12'h010, 0, rd); check("R3 loaded seconds visible", rd, 1000);
    access(1'b0, 12'h020, 0, rd); check("R2 snap us in range", {31'd0, rd < US_PER_S}, 32'd1);

    // R6 rate 10: one tick each 5 us = 20 clocks
    access(1'b1, 12'h100, 32'd10, rd);     // edge E
    idle(14);
    access(1'b0, 12'h110, 0, rd); check("R4 no tick before first period", rd, 0);
    idle(47);
    access(1'b1, 12'h100, 32'd0, rd);      // E+63: three ticks seen
    check("R8 irq high with pending", {31'd0, irq_o}, 32'd1);
    access(1'b0, 12'h110, 0, rd); check("R6 three ticks counted", rd, 3);
    access(1'b0, 12'h110, 0, rd); check("R7 one retired per ack", rd, 2);
    access(1'b0, 12'h110, 0, rd); check("R7 one retired per ack", rd, 1);
    check("R8 irq low when drained", {31'd0, irq_o}, 32'd0);
    access(1'b0, 12'h110, 0, rd); check("R7 ack at zero stays zero", rd, 0);

    // R4 rewrites restart the phase: no tick ever
    access(1'b1, 12'h100, 32'd10, rd);
    for (int k = 0; k < 6; k++) begin
      idle(11);
      access(1'b1, 12'h100, 32'd10, rd);
    end
    access(1'b1, 12'h100, 32'd0, rd);
    access(1'b0, 12'h110, 0, rd); check("R4 restart suppresses ticks", rd, 0);

    // R4 clamp, R8 saturation, R7 tick and ack in one cycle
    access(1'b1, 12'h100, 32'd1000, rd);
    access(1'b0, 12'h100, 0, rd); check("R4 rate clamped", rd, US_PER_S);
    idle(100);
    access(1'b0, 12'h110, 0, rd); check("R8 pending saturated", rd, PEND_MAX);
    access(1'b1, 12'h110, 0, rd);
    access(1'b1, 12'h110, 0, rd);
    access(1'b1, 12'h110, 0, rd);
    access(1'b0, 12'h110, 0, rd); check("R7 tick and ack same cycle", rd, PEND_MAX - 4 + 1);
    check("R8 irq high", {31'd0, irq_o}, 32'd1);

    // R9 reset mid-run
    do_reset();
    check("R9 irq cleared by reset", {31'd0, irq_o}, 32'd0);
    access(1'b0, 12'h100, 0, rd); check("R9 rate cleared by reset", rd, 0);
    access(1'b0, 12'h110, 0, rd); check("R9 pending cleared by reset", rd, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule